// File: doc/BRIEF.md
# Ethernet PHY Control Register and Mode Resolver

This block holds the basic control word of a 10/100 Ethernet PHY. It also decides which operating mode the PHY actually runs in. Software writes and reads the word through a plain register port with address, data and write strobe. The mode is resolved from three sources:

- the stored control bits;
- a strap pin that selects hardware or software control, plus strap pins for speed and auto-negotiation;
- the result handed over by an auto-negotiation engine.

The block drives out the effective speed, duplex and auto-negotiation enable. It also drives the enables for the line transmitter, the line receiver and the collision detector.

When loopback is set, the line side is switched off. The MII transmit nibble and enable then return on the MII receive nibble and valid after a fixed four-clock pipeline. A separate control bit can keep the collision detector running during loopback. A change of the loopback bit takes effect only between frames, while transmit-enable is low.

Top module: `phy_mode_ctrl`

## Requirements
- R1: After reset, reading address 0 returns 0x1000: auto-negotiation enable (bit 12) is set and every other bit is clear.
- R2: A write to address 0 stores bits 14, 13, 12, 8 and 7. All other bit positions read back as 0. A write to any other address changes nothing, and reads of other addresses return 0.
- R3: With `sw_mode` low (hardware control), `eff_fast` equals `strap_fast` and `eff_aneg` equals `strap_aneg`. Stored bits 13 and 12 have no effect.
- R4: With `sw_mode` high and bit 12 set, `eff_aneg` is 1, `eff_fast` equals `an_fast` and `eff_full` equals `an_full`. Bits 13 and 8 have no effect.
- R5: With `sw_mode` high and bit 12 clear, `eff_aneg` is 0. Bit 13 selects the speed (0 = 10 Mb/s, 1 = 100 Mb/s) and bit 8 selects the duplex (1 = full).
- R6: With `sw_mode` low, `eff_full` equals `an_full` when `strap_aneg` is 1, and equals bit 8 otherwise.
- R7: While loopback is active, `line_tx_en` and `line_rx_en` are 0 and `col_det_en` equals bit 7. Outside loopback all three enables are 1.
- R8: While loopback is active, `mii_rxd`/`mii_rx_dv` repeat `mii_txd`/`mii_tx_en` exactly 4 clocks later. Outside loopback they pass `line_rxd`/`line_rx_dv` straight through.
- R9: A change of bit 14 reaches the loopback state only on a clock where `mii_tx_en` is low. While `mii_tx_en` stays high, the previous loopback state holds.
- R10: Bits that the current mode ignores still read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| sw_mode | input | 1 | Strap: 1 = software control, 0 = hardware control |
| strap_fast | input | 1 | Strap speed select, 1 = 100 Mb/s |
| strap_aneg | input | 1 | Strap auto-negotiation enable |
| an_fast | input | 1 | Auto-negotiation result: 100 Mb/s |
| an_full | input | 1 | Auto-negotiation result: full duplex |
| eff_fast | output | 1 | Effective speed, 1 = 100 Mb/s |
| eff_full | output | 1 | Effective duplex, 1 = full |
| eff_aneg | output | 1 | Effective auto-negotiation enable |
| line_tx_en | output | 1 | Line transmitter enable |
| line_rx_en | output | 1 | Line receiver enable |
| col_det_en | output | 1 | Collision detector enable |
| mii_txd | input | 4 | MII transmit nibble |
| mii_tx_en | input | 1 | MII transmit enable |
| line_rxd | input | 4 | Receive nibble from the line side |
| line_rx_dv | input | 1 | Receive valid from the line side |
| mii_rxd | output | 4 | MII receive nibble |
| mii_rx_dv | output | 1 | MII receive valid |

## Verification
The bench covers every combination of strap, control bits and negotiation result. It compares each outputs against a model. A resolver that let an isolated bit through would show the stored bit 13 or bit 8 where the strap or negotiated value belongs.

The bench writes the loopback bit in the middle of a frame. A design that did not wait for transmit-enable to fall would cut the line side off at once.

The loopback stream is checked nibble by nibble at a delay of exactly four clocks, so one stage too many or too few is caught. The collision override is tested in both states. The ignored bit positions and foreign addresses are read back to show that they store nothing.

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NIB_W     = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sw_mode,
  input  logic              strap_fast,
  input  logic              strap_aneg,
  input  logic              an_fast,
  input  logic              an_full,
  output logic              eff_fast,
  output logic              eff_full,
  output logic              eff_aneg,
  output logic              line_tx_en,
  output logic              line_rx_en,
  output logic              col_det_en,
  input  logic [NIB_W-1:0]  mii_txd,
  input  logic              mii_tx_en,
  input  logic [NIB_W-1:0]  line_rxd,
  input  logic              line_rx_dv,
  output logic [NIB_W-1:0]  mii_rxd,
  output logic              mii_rx_dv
);
  localparam int LB_DEPTH = 4;
  localparam int B_LOOP = 14, B_FAST = 13, B_ANEG = 12, B_FULL = 8, B_COL = 7;

  logic ctl_loop, ctl_fast, ctl_aneg, ctl_full, ctl_col;
  logic lb_on;
  logic [NIB_W:0] lb_pipe [LB_DEPTH];
  logic [DATA_W-1:0] ctl_word;
  logic ctl_hit;

  assign ctl_hit = reg_addr == CTRL_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_loop <= 1'b0;
      ctl_fast <= 1'b0;
      ctl_aneg <= 1'b1;
      ctl_full <= 1'b0;
      ctl_col  <= 1'b0;
    end else if (reg_we && ctl_hit) begin
      ctl_loop <= reg_wdata[B_LOOP];
      ctl_fast <= reg_wdata[B_FAST];
      ctl_aneg <= reg_wdata[B_ANEG];
      ctl_full <= reg_wdata[B_FULL];
      ctl_col  <= reg_wdata[B_COL];
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[B_LOOP] = ctl_loop;
    ctl_word[B_FAST] = ctl_fast;
    ctl_word[B_ANEG] = ctl_aneg;
    ctl_word[B_FULL] = ctl_full;
    ctl_word[B_COL]  = ctl_col;
  end

  assign reg_rdata = ctl_hit ? ctl_word : '0;

  assign eff_aneg = sw_mode ? ctl_aneg : strap_aneg;
  assign eff_fast = !sw_mode ? strap_fast : (ctl_aneg ? an_fast : ctl_fast);
  assign eff_full = eff_aneg ? an_full : ctl_full;

  always_ff @(posedge clk) begin
    if (!rst_n) lb_on <= 1'b0;
    else if (!mii_tx_en) lb_on <= ctl_loop;
  end

  assign line_tx_en = !lb_on;
  assign line_rx_en = !lb_on;
  assign col_det_en = !lb_on || ctl_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LB_DEPTH; i++) lb_pipe[i] <= '0;
    end else begin
      lb_pipe[0] <= {mii_tx_en, mii_txd};
      for (int i = 1; i < LB_DEPTH; i++) lb_pipe[i] <= lb_pipe[i-1];
    end
  end

  assign mii_rxd   = lb_on ? lb_pipe[LB_DEPTH-1][NIB_W-1:0] : line_rxd;
  assign mii_rx_dv = lb_on ? lb_pipe[LB_DEPTH-1][NIB_W]     : line_rx_dv;

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ctl_hit) |=> (ctl_word == ($past(reg_wdata) & 16'h7180)));
  p_hw_strap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode |-> (eff_fast == strap_fast && eff_aneg == strap_aneg));
  p_sw_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && !ctl_aneg) |-> (eff_fast == ctl_fast && eff_full == ctl_full && !eff_aneg));
  p_lb_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_on |-> (!line_tx_en && !line_rx_en && col_det_en == ctl_col));
  p_lb_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_on && $past(rst_n, 4)) |-> ({mii_rx_dv, mii_rxd} == $past({mii_tx_en, mii_txd}, 4)));
  p_lb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mii_tx_en |=> $stable(lb_on));
endmodule

// File: tb/tb_phy_mode_ctrl.sv
`timescale 1ns/1ps
module tb_phy_mode_ctrl;
  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic reg_we = 0;
  logic sw_mode = 1, strap_fast = 0, strap_aneg = 0, an_fast = 0, an_full = 0;
  logic eff_fast, eff_full, eff_aneg, line_tx_en, line_rx_en, col_det_en;
  logic [3:0] mii_txd = 0, line_rxd = 0, mii_rxd;
  logic mii_tx_en = 0, line_rx_dv = 0, mii_rx_dv;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  phy_mode_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0; reg_addr = 0;
  endtask

  function automatic logic [2:0] model(input logic sw, input logic sf, input logic sa,
                                       input logic af, input logic au, input logic [15:0] c);
    logic an, fast, full;
    an   = sw ? c[12] : sa;
    fast = !sw ? sf : (c[12] ? af : c[13]);
    full = an ? au : c[8];
    return {fast, full, an};
  endfunction

  initial begin
    #(5ns * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] cw;
    logic [2:0] e;
    logic [4:0] hist [256];
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 16'h1000, "R1 reset value", reg_rdata, 16'h1000);
    chk(line_tx_en && line_rx_en && col_det_en, "R7 enables after reset",
        {line_tx_en, line_rx_en, col_det_en}, 3'b111);

    wr(0, 16'hFFFF);
    chk(reg_rdata == 16'h7180, "R2 writable mask", reg_rdata, 16'h7180);
    wr(0, 16'h0000);
    wr(5'd3, 16'hFFFF);
    chk(reg_rdata == 16'h0000, "R2 foreign write ignored", reg_rdata, 16'h0000);
    reg_addr = 5'd3; #1;
    chk(reg_rdata == 16'h0000, "R2 foreign read zero", reg_rdata, 16'h0000);
    reg_addr = 0;

    for (int i = 0; i < 200; i++) begin
      cw = 16'($urandom) & 16'h3180;
      wr(0, cw);
      sw_mode = 1'($urandom); strap_fast = 1'($urandom); strap_aneg = 1'($urandom);
      an_fast = 1'($urandom); an_full = 1'($urandom);
      #1;
      e = model(sw_mode, strap_fast, strap_aneg, an_fast, an_full, cw);
      if (!sw_mode)
        chk({eff_fast, eff_aneg} == {e[2], e[0]}, "R3 hw strap speed/aneg", {eff_fast, eff_aneg}, {e[2], e[0]});
      else if (cw[12])
        chk({eff_fast, eff_full, eff_aneg} == e, "R4 sw negotiated mode", {eff_fast, eff_full, eff_aneg}, e);
      else
        chk({eff_fast, eff_full, eff_aneg} == e, "R5 sw manual mode", {eff_fast, eff_full, eff_aneg}, e);
      if (!sw_mode)
        chk(eff_full == e[1], "R6 hw duplex", eff_full, e[1]);
      chk(reg_rdata == cw, "R10 readback of isolated bits", reg_rdata, cw);
    end

    sw_mode = 0; strap_fast = 1; strap_aneg = 0;
    wr(0, 16'h0000); #1;
    chk(eff_fast == 1 && eff_aneg == 0, "R3 directed strap over bit13/12",
        {eff_fast, eff_aneg}, 2'b10);
    sw_mode = 1; an_fast = 0; an_full = 1;
    wr(0, 16'h3100); #1;
    chk({eff_fast, eff_full, eff_aneg} == 3'b011, "R4 directed isolation of bits 13/8",
        {eff_fast, eff_full, eff_aneg}, 3'b011);

    line_rxd = 4'hA; line_rx_dv = 1; #1;
    chk({mii_rx_dv, mii_rxd} == 5'h1A, "R8 passthrough outside loopback", {mii_rx_dv, mii_rxd}, 5'h1A);

    @(negedge clk); mii_tx_en = 1;
    wr(0, 16'h4000);
    repeat (4) @(negedge clk);
    chk(line_tx_en == 1, "R9 loopback held mid-frame", line_tx_en, 1);
    mii_tx_en = 0;
    repeat (2) @(negedge clk);
    chk({line_tx_en, line_rx_en, col_det_en} == 3'b000, "R7 loopback line off",
        {line_tx_en, line_rx_en, col_det_en}, 3'b000);
    wr(0, 16'h4080); #1;
    chk(col_det_en == 1, "R7 collision override", col_det_en, 1);

    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      if (j >= 4)
        chk({mii_rx_dv, mii_rxd} == hist[j-4], "R8 loopback 4-cycle delay", {mii_rx_dv, mii_rxd}, hist[j-4]);
      mii_txd = 4'($urandom); mii_tx_en = (j % 40) < 30;
      hist[j] = {mii_tx_en, mii_txd};
    end

    @(negedge clk); mii_tx_en = 0;
    wr(0, 16'h0000);
    repeat (2) @(negedge clk);
    chk({line_tx_en, col_det_en} == 2'b11, "R9 loopback exit between frames", {line_tx_en, col_det_en}, 2'b11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule